// File: doc/BRIEF.md
# Receiver Front-End Serial Control Register

This block is the digital control slice of a three-path receive amplifier front end. A host writes a framed serial word on three pins: a serial clock, a data line and a frame strobe. The word names one of three on-chip amplifier paths, or a fourth external amplifier, and gives it an operating mode and a bias-current level. The block keeps a mode register and a current register for each on-chip path. It also keeps a two-pin output that steers the external amplifier. Serial pins are sampled by the system clock, so the serial clock must run well below the system clock.

A frame is 30 bits long and is sent most significant bit first. Bits 29..23 must match a fixed identity pattern. Bit 22 selects write (0) or read (1). Bits 21..19 select the target. In the data half, bit 15 is the gain bit, bit 14 is the enable bit and bits 13..11 are the current code. A read frame is one bit longer. The extra bit is a turnaround slot, and after it the block shifts out a 16-bit word whose low nine bits are a fixed hardware identifier.

Power-on reset puts every path into bypass. A deep-sleep input forces every path, including the external one, into the disabled mode while it is held.

Top module: `rxfe_ctl_top`

## Requirements
- R1: After reset every path mode reads 2'b00 (bypass), `gpo_o` is 2'b01 and `ser_dout_o` is 0.
- R2: After reset the current codes are 2 for path 0 (high band 2) and 6 for path 1 (high band 1) and path 2 (low band).
- R3: A valid write sets the selected path's mode pair to {bit 15 gain, bit 14 enable}: 2'b11 is active, 2'b00 is bypass and 2'b10 is disabled. Every other path keeps its mode.
- R4: A valid write to an on-chip path loads frame bits 13..11 into that path's 3-bit current code. Other paths keep their codes.
- R5: A write that carries the unused mode pair 2'b01 changes nothing.
- R6: A frame whose bits 29..23 differ from 7'b1010000 changes nothing.
- R7: Selector 3'b001 targets path 0, 3'b010 targets path 1, 3'b011 targets path 2 and 3'b100 targets the external amplifier. Any other selector changes nothing.
- R8: A write frame takes effect only when the frame ends after exactly 30 serial rising edges. Any other length, and any frame with the read flag set, changes no register.
- R9: A write to the external target sets `gpo_o` to 2'b11 for active, 2'b01 for bypass and 2'b00 for disabled. The current codes are unaffected.
- R10: In a read frame with a matching identity, the rising edges numbered 15 through 30 each present one bit on `ser_dout_o`. Together these bits form the 16-bit word {7'b0, HW_ID}, most significant bit first, and edge 15 is the turnaround. `ser_dout_o` is 0 when no frame is active.
- R11: While `sleep_i` is high, every path mode is 2'b10 and `gpo_o` is 2'b00, and writes are ignored. After release the disabled state remains until it is rewritten.
- R12: Register outputs change on the third system clock rising edge after the frame pin falls, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_i | input | 1 | Deep-sleep request, forces all paths to disabled |
| ser_clk_i | input | 1 | Serial clock, data captured on its rising edge |
| ser_data_i | input | 1 | Serial data in, MSB first |
| ser_frame_i | input | 1 | Frame strobe, high for the length of a word |
| ser_dout_o | output | 1 | Serial read data |
| path_mode_o | output | 2*NUM_PATHS | Mode pair {gain, enable} for each on-chip path, path 0 in the low bits |
| path_cur_o | output | 3*NUM_PATHS | Current code for each on-chip path, path 0 in the low bits |
| gpo_o | output | 2 | External amplifier control |

## Verification
A write becomes visible three system clock edges after the frame pin falls. The first edge registers the pins, the second latches the decoded fields, and the third updates the path registers. The bench drives inputs at falling edges. For the latency test it samples two falling edges after the frame falls, where the old value must still be present, and again one edge later, where the new value must appear. Read data is sampled several system cycles after each serial rising edge, when it is stable. The sleep override is sampled one edge after the request is raised.

// File: rtl/rxfe_ctl_pkg.sv
package rxfe_ctl_pkg;

  typedef enum logic [1:0] {
    MD_BYPASS  = 2'b00,
    MD_UNUSED  = 2'b01,
    MD_DISABLE = 2'b10,
    MD_ACTIVE  = 2'b11
  } mode_e;

  // External amplifier pin encoding
  function automatic logic [1:0] gpo_of(mode_e m);
    case (m)
      MD_ACTIVE: return 2'b11;
      MD_BYPASS: return 2'b01;
      default:   return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/rxfe_in_sync.sv
module rxfe_in_sync (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk_i,
  input  logic ser_data_i,
  input  logic ser_frame_i,
  output logic rise_o,
  output logic frame_act_o,
  output logic frame_end_o,
  output logic bit_o
);
  logic clk_s1, clk_s2, frm_s1, frm_s2, dat_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_s1 <= 1'b0;
      clk_s2 <= 1'b0;
      frm_s1 <= 1'b0;
      frm_s2 <= 1'b0;
      dat_s1 <= 1'b0;
    end else begin
      clk_s1 <= ser_clk_i;
      clk_s2 <= clk_s1;
      frm_s1 <= ser_frame_i;
      frm_s2 <= frm_s1;
      dat_s1 <= ser_data_i;
    end
  end

  assign rise_o      = clk_s1 & ~clk_s2;
  assign frame_act_o = frm_s1;
  assign frame_end_o = frm_s2 & ~frm_s1;
  assign bit_o       = dat_s1;
endmodule

// File: rtl/rxfe_frame_rx.sv
module rxfe_frame_rx
  import rxfe_ctl_pkg::*;
#(
  parameter int WORD_W    = 30,
  parameter int DATA_W    = 16,
  parameter int PAT_W     = 7,
  parameter logic [PAT_W-1:0] PAT = 7'b1010000,
  parameter int SEL_W     = 3,
  parameter int CUR_W     = 3,
  parameter int NUM_PATHS = 3,
  parameter int ID_W      = 9,
  parameter logic [ID_W-1:0] HW_ID = 9'h0B3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             frame_act_i,
  input  logic             frame_end_i,
  input  logic             bit_i,
  output logic             apply_o,
  output logic [SEL_W-1:0] sel_o,
  output mode_e            mode_o,
  output logic [CUR_W-1:0] cur_o,
  output logic             dout_o
);
  localparam int RD_W    = WORD_W + 1;
  localparam int ADDR_W  = WORD_W - DATA_W;
  localparam int CNT_W   = $clog2(RD_W + 2) + 1;
  localparam int RW_POS  = WORD_W - PAT_W - 1;
  localparam int SEL_HI  = RW_POS - 1;
  localparam int GAIN_P  = DATA_W - 1;
  localparam int EN_P    = DATA_W - 2;
  localparam int CUR_HI  = DATA_W - 3;
  localparam int TURN    = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [RD_W-1:0]   sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] ob_q;
  logic [WORD_W-1:0] word;
  logic [SEL_W-1:0]  sel_f;
  mode_e             mode_f;
  logic              sel_ok, wr_ok, turn_ok;

  always_comb begin
    sh_n    = {sh_q[RD_W-2:0], bit_i};
    cnt_n   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    turn_ok = (sh_n[TURN-1 -: PAT_W] == PAT) && sh_n[TURN-1-PAT_W];
    word    = sh_q[WORD_W-1:0];
    sel_f   = word[SEL_HI -: SEL_W];
    mode_f  = mode_e'({word[GAIN_P], word[EN_P]});
    sel_ok  = (sel_f != '0) && (sel_f <= SEL_W'(NUM_PATHS + 1));
    wr_ok   = (cnt_q == CNT_W'(WORD_W)) &&
              (word[WORD_W-1 -: PAT_W] == PAT) &&
              !word[RW_POS] && sel_ok && (mode_f != MD_UNUSED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      ob_q    <= '0;
      apply_o <= 1'b0;
      sel_o   <= '0;
      mode_o  <= MD_BYPASS;
      cur_o   <= '0;
    end else begin
      apply_o <= frame_end_i & wr_ok;
      sel_o   <= sel_f;
      mode_o  <= mode_f;
      cur_o   <= word[CUR_HI -: CUR_W];
      if (frame_end_i) begin
        cnt_q <= '0;
        ob_q  <= '0;
      end else if (rise_i && frame_act_i) begin
        sh_q  <= sh_n;
        cnt_q <= cnt_n;
        if (cnt_n == CNT_W'(TURN) && turn_ok)
          ob_q <= DATA_W'(HW_ID);
        else
          ob_q <= {ob_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign dout_o = ob_q[DATA_W-1];
endmodule

// File: rtl/rxfe_path_bank.sv
module rxfe_path_bank
  import rxfe_ctl_pkg::*;
#(
  parameter int NUM_PATHS = 3,
  parameter int CUR_W     = 3,
  parameter int SEL_W     = 3,
  parameter logic [NUM_PATHS*CUR_W-1:0] CUR_RST = 9'b110_110_010
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sleep_i,
  input  logic                       apply_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  mode_e                      mode_i,
  input  logic [CUR_W-1:0]           cur_i,
  output logic [NUM_PATHS*2-1:0]     mode_o,
  output logic [NUM_PATHS*CUR_W-1:0] cur_o,
  output logic [1:0]                 gpo_o
);
  localparam logic [SEL_W-1:0] EXT_SEL = SEL_W'(NUM_PATHS + 1);

  for (genvar i = 0; i < NUM_PATHS; i++) begin : g_path
    logic [1:0]       md_q;
    logic [CUR_W-1:0] cu_q;
    logic             hit;
    assign hit = apply_i && (sel_i == SEL_W'(i + 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        md_q <= MD_BYPASS;
        cu_q <= CUR_RST[i*CUR_W +: CUR_W];
      end else if (sleep_i) begin
        md_q <= MD_DISABLE;
      end else if (hit) begin
        md_q <= mode_i;
        cu_q <= cur_i;
      end
    end
    assign mode_o[i*2 +: 2]      = md_q;
    assign cur_o[i*CUR_W +: CUR_W] = cu_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      gpo_o <= gpo_of(MD_BYPASS);
    else if (sleep_i)
      gpo_o <= gpo_of(MD_DISABLE);
    else if (apply_i && sel_i == EXT_SEL)
      gpo_o <= gpo_of(mode_i);
  end
endmodule

// File: rtl/rxfe_ctl_top.sv
module rxfe_ctl_top
  import rxfe_ctl_pkg::*;
#(
  parameter int NUM_PATHS = 3,
  parameter int CUR_W     = 3,
  parameter int WORD_W    = 30,
  parameter int DATA_W    = 16,
  parameter int PAT_W     = 7,
  parameter logic [PAT_W-1:0] PAT = 7'b1010000,
  parameter int SEL_W     = 3,
  parameter int ID_W      = 9,
  parameter logic [ID_W-1:0] HW_ID = 9'h0B3,
  parameter logic [NUM_PATHS*CUR_W-1:0] CUR_RST = 9'b110_110_010
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sleep_i,
  input  logic                       ser_clk_i,
  input  logic                       ser_data_i,
  input  logic                       ser_frame_i,
  output logic                       ser_dout_o,
  output logic [NUM_PATHS*2-1:0]     path_mode_o,
  output logic [NUM_PATHS*CUR_W-1:0] path_cur_o,
  output logic [1:0]                 gpo_o
);
  logic             rise_w, fact_w, fend_w, bit_w, apply_w;
  logic [SEL_W-1:0] sel_w;
  mode_e            mode_w;
  logic [CUR_W-1:0] cur_w;

  rxfe_in_sync u_sync (
    .clk(clk), .rst(rst),
    .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_frame_i(ser_frame_i),
    .rise_o(rise_w), .frame_act_o(fact_w), .frame_end_o(fend_w), .bit_o(bit_w)
  );

  rxfe_frame_rx #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .PAT_W(PAT_W), .PAT(PAT),
    .SEL_W(SEL_W), .CUR_W(CUR_W), .NUM_PATHS(NUM_PATHS),
    .ID_W(ID_W), .HW_ID(HW_ID)
  ) u_rx (
    .clk(clk), .rst(rst),
    .rise_i(rise_w), .frame_act_i(fact_w), .frame_end_i(fend_w), .bit_i(bit_w),
    .apply_o(apply_w), .sel_o(sel_w), .mode_o(mode_w), .cur_o(cur_w),
    .dout_o(ser_dout_o)
  );

  rxfe_path_bank #(
    .NUM_PATHS(NUM_PATHS), .CUR_W(CUR_W), .SEL_W(SEL_W), .CUR_RST(CUR_RST)
  ) u_bank (
    .clk(clk), .rst(rst), .sleep_i(sleep_i),
    .apply_i(apply_w), .sel_i(sel_w), .mode_i(mode_w), .cur_i(cur_w),
    .mode_o(path_mode_o), .cur_o(path_cur_o), .gpo_o(gpo_o)
  );
endmodule

// File: rtl/rxfe_ctl_chk.sv
module rxfe_ctl_chk #(
  parameter int NUM_PATHS = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   sleep_i,
  input logic                   ser_frame_i,
  input logic                   ser_dout_o,
  input logic [NUM_PATHS*2-1:0] path_mode_o,
  input logic [1:0]             gpo_o,
  input logic                   apply_w
);
  logic [2:0] seen_q = '0;
  logic       rst_d  = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) seen_q <= '0;
    else if (seen_q != 3'd7) seen_q <= seen_q + 1'b1;
  end

  function automatic logic any_unused(logic [NUM_PATHS*2-1:0] v);
    for (int i = 0; i < NUM_PATHS; i++)
      if (v[i*2 +: 2] == 2'b01) return 1'b1;
    return 1'b0;
  endfunction

  // R1
  always_ff @(posedge clk) begin
    if (rst_d) begin
      reset_bypass_chk: assert (path_mode_o == '0 && gpo_o == 2'b01)
        else $error("reset state wrong");
    end
  end

  // R11
  sleep_disable_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> (path_mode_o == {NUM_PATHS{2'b10}} && gpo_o == 2'b00));

  // R5
  no_unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 3'd0) |-> !any_unused(path_mode_o));

  // R12
  mode_change_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q >= 3'd2 && path_mode_o != $past(path_mode_o))
      |-> ($past(apply_w) || $past(sleep_i)));

  // R10
  idle_dout_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q >= 3'd4 && !$past(ser_frame_i) && !$past(ser_frame_i, 2) &&
     !$past(ser_frame_i, 3)) |-> !ser_dout_o);
endmodule

bind rxfe_ctl_top rxfe_ctl_chk #(.NUM_PATHS(NUM_PATHS)) u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .ser_frame_i(ser_frame_i),
  .ser_dout_o(ser_dout_o), .path_mode_o(path_mode_o), .gpo_o(gpo_o),
  .apply_w(apply_w)
);

// File: tb/rxfe_ctl_top_tb_top.sv
module rxfe_ctl_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_i = 1'b0;
  logic ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_frame_i = 1'b0;
  logic ser_dout_o;
  logic [5:0] path_mode_o;
  logic [8:0] path_cur_o;
  logic [1:0] gpo_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [1:0] e_md [3];
  logic [2:0] e_cu [3];
  logic [1:0] e_gpo;
  logic [30:0] rd_bits;

  localparam logic [8:0] HW_ID = 9'h0B3;

  always #2 clk = ~clk;

  rxfe_ctl_top dut_i (
    .clk(clk), .rst(rst), .sleep_i(sleep_i),
    .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_frame_i(ser_frame_i),
    .ser_dout_o(ser_dout_o), .path_mode_o(path_mode_o),
    .path_cur_o(path_cur_o), .gpo_o(gpo_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, {26'b0, path_mode_o}, {26'b0, e_md[2], e_md[1], e_md[0]});
    check(req, {23'b0, path_cur_o},  {23'b0, e_cu[2], e_cu[1], e_cu[0]});
    check(req, {30'b0, gpo_o},       {30'b0, e_gpo});
  endtask

  function automatic logic [30:0] wr_word(logic [6:0] pat, logic rw,
                                          logic [2:0] sel, logic [1:0] md,
                                          logic [2:0] cur);
    return {1'b0, pat, rw, sel, 3'b000, md, cur, 11'b0};
  endfunction

  task automatic send_frame(logic [30:0] w, int n);
    ser_frame_i = 1'b1;
    tick(2);
    for (int k = 0; k < n; k++) begin
      ser_data_i = w[n-1-k];
      tick(2);
      ser_clk_i = 1'b1;
      tick(4);
      rd_bits[k] = ser_dout_o;
      ser_clk_i = 1'b0;
      tick(2);
    end
    ser_frame_i = 1'b0;
  endtask

  task automatic do_write(logic [2:0] sel, logic [1:0] md, logic [2:0] cur);
    send_frame(wr_word(7'b1010000, 1'b0, sel, md, cur), 30);
    tick(4);
  endtask

  task automatic t_reset;
    e_md = '{2'b00, 2'b00, 2'b00};
    e_cu = '{3'd2, 3'd6, 3'd6};
    e_gpo = 2'b01;
    check_all("R1/R2 reset");
    check("R1 dout idle", {31'b0, ser_dout_o}, 32'd0);
  endtask

  task automatic t_writes;
    do_write(3'b011, 2'b11, 3'd5); e_md[2] = 2'b11; e_cu[2] = 3'd5;
    check_all("R3/R4 low band active");
    do_write(3'b001, 2'b10, 3'd7); e_md[0] = 2'b10; e_cu[0] = 3'd7;
    check_all("R3/R4 path0 disable");
    do_write(3'b010, 2'b11, 3'd0); e_md[1] = 2'b11; e_cu[1] = 3'd0;
    check_all("R3 path1 active");
    do_write(3'b010, 2'b00, 3'd3); e_md[1] = 2'b00; e_cu[1] = 3'd3;
    check_all("R3 path1 bypass");
  endtask

  task automatic t_rejects;
    do_write(3'b001, 2'b01, 3'd1);
    check_all("R5 unused code");
    send_frame(wr_word(7'b1010001, 1'b0, 3'b001, 2'b11, 3'd1), 30); tick(4);
    check_all("R6 identity mismatch");
    do_write(3'b000, 2'b11, 3'd1);
    check_all("R7 selector 000");
    do_write(3'b101, 2'b11, 3'd1);
    check_all("R7 selector 101");
    send_frame(wr_word(7'b1010000, 1'b0, 3'b001, 2'b11, 3'd1), 29); tick(4);
    check_all("R8 short write");
    send_frame({wr_word(7'b1010000, 1'b0, 3'b001, 2'b11, 3'd1), 1'b0}, 31); tick(4);
    check_all("R8 long write");
    send_frame(wr_word(7'b1010000, 1'b1, 3'b001, 2'b11, 3'd1), 30); tick(4);
    check_all("R8 read flag 30 bits");
  endtask

  task automatic t_ext;
    do_write(3'b100, 2'b11, 3'd4); e_gpo = 2'b11;
    check_all("R9 ext active");
    do_write(3'b100, 2'b10, 3'd1); e_gpo = 2'b00;
    check_all("R9 ext disable");
    do_write(3'b100, 2'b00, 3'd1); e_gpo = 2'b01;
    check_all("R9 ext bypass");
  endtask

  task automatic t_read;
    logic [15:0] got;
    logic [15:0] exp;
    exp = {7'b0, HW_ID};
    send_frame({wr_word(7'b1010000, 1'b1, 3'b001, 2'b00, 3'd0), 1'b0}, 31);
    for (int k = 14; k < 30; k++) got[29-k] = rd_bits[k];
    tick(4);
    check("R10 read id", {16'b0, got}, {16'b0, exp});
    check("R10 dout idle after read", {31'b0, ser_dout_o}, 32'd0);
    check_all("R8 read leaves registers");
    send_frame({wr_word(7'b1110000, 1'b1, 3'b001, 2'b00, 3'd0), 1'b0}, 31);
    for (int k = 14; k < 30; k++) got[29-k] = rd_bits[k];
    tick(4);
    check("R10 bad identity read gives zero", {16'b0, got}, 32'd0);
  endtask

  task automatic t_latency;
    send_frame(wr_word(7'b1010000, 1'b0, 3'b001, 2'b11, 3'd6), 30);
    tick(2);
    check_all("R12 not yet applied");
    tick(1);
    e_md[0] = 2'b11; e_cu[0] = 3'd6;
    check_all("R12 applied third edge");
  endtask

  task automatic t_sleep;
    sleep_i = 1'b1;
    tick(1);
    e_md = '{2'b10, 2'b10, 2'b10}; e_gpo = 2'b00;
    check_all("R11 sleep forces disable");
    do_write(3'b011, 2'b11, 3'd2);
    check_all("R11 write during sleep ignored");
    sleep_i = 1'b0;
    tick(2);
    check_all("R11 stays disabled after release");
    do_write(3'b011, 2'b11, 3'd2); e_md[2] = 2'b11; e_cu[2] = 3'd2;
    check_all("R11 write after release");
  endtask

  task automatic t_reset_again;
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    t_reset();
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_writes();
    t_rejects();
    t_ext();
    t_read();
    t_latency();
    t_sleep();
    t_reset_again();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule